// File: doc/BRIEF.md
# Packed Rounding Butterfly Multiplier

This block takes three 64-bit words, T, A and B. Each word holds signed lanes of one common width. In every lane the block forms the sum T+A and the difference T−A. It multiplies each of them by the B lane, rounds the product half-up at a chosen binary point, and shifts it right arithmetically. Only the low lane-width bits of each result are kept. The two 64-bit results leave together, one on `out_sum` and one on `out_dif`. This is the core step of a fixed-point butterfly, used in transforms that scale and round every coefficient product.

The lane width is chosen at run time for each operation through `in_mode`. The right shift is chosen through `in_shift`. Both are captured together with the operands on the accepting edge. The operation flows through a single output register. A two-state occupancy machine controls that register. `ST_EMPTY` means no result is held. `ST_FULL` means a result is waiting for the consumer.

The machine has four transitions:
- It goes from `ST_EMPTY` to `ST_FULL` on an accept.
- It stays in `ST_FULL` while the consumer stalls, or when it drains and accepts on the same edge.
- It goes from `ST_FULL` to `ST_EMPTY` on a drain with no new accept.
- It stays in `ST_EMPTY` while idle.

Top module: `bfly_mac`

## Requirements
- R1: `in_mode` selects the lane width: 0 gives 8 bits, 1 gives 16, 2 gives 32 and 3 gives 64. There are 64/width lanes. Lane i occupies bits [i*width +: width] of every operand and result, so lane 0 sits in the least significant bits.
- R2: Every lane of T, A and B is read as a two's-complement signed value.
- R3: Lane i of `out_sum` equals floor((t+a)*b / 2^shift + 1/2), reduced modulo 2^width.
- R4: Lane i of `out_dif` equals floor((t−a)*b / 2^shift + 1/2), reduced modulo 2^width.
- R5: Exact ties round toward positive infinity, for negative products as well. For example, a product of −3 with a shift of 1 gives −1.
- R6: Results wrap modulo 2^width without saturation. The sum and difference of extreme lanes, such as two most-negative values, are formed without intermediate overflow.
- R7: With a shift of 0, the rounding addend has no effect, and the result is the low width bits of the exact product.
- R8: An operation accepted on a clock edge (`in_valid` and `in_ready` both high) is presented with `out_valid` high after exactly one edge. Back-to-back accepts sustain one operation per cycle.
- R9: `in_ready` is high whenever no result is held or `out_ready` is high. While `out_valid` is high and `out_ready` is low, both results hold steady. After a drain with no new accept, `out_valid` falls.
- R10: `in_mode`, `in_shift` and the operands are captured only on an accept. Changing them afterwards does not alter a held result.
- R11: While reset is asserted, `out_valid` is low and `in_ready` is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | 1 | Producer offers an operation |
| in_ready | output | 1 | Block can accept this cycle |
| in_mode | input | 2 | Lane width code (0:8, 1:16, 2:32, 3:64) |
| in_shift | input | 6 | Right-shift amount after rounding |
| in_t | input | 64 | Packed T operand |
| in_a | input | 64 | Packed A operand |
| in_b | input | 64 | Packed B operand |
| out_valid | output | 1 | A result is held |
| out_ready | input | 1 | Consumer takes the held result |
| out_sum | output | 64 | Packed rounded (T+A)*B results |
| out_dif | output | 64 | Packed rounded (T−A)*B results |

## Verification
The assertions assume the producer never offers a shift at or above min(32, width) for the chosen mode. They also assume the handshake inputs are defined from reset onward. The sweeps respect this: for each mode, the bench steps the shift from 0 up to min(32, width) − 1 and never beyond. It drives every input half a cycle away from the sampling edge. Within that legal range, the stimulus mixes random lanes with lanes at the most negative value, the most positive value and zero.

// File: rtl/bfly_pkg.sv
package bfly_pkg;

    typedef enum logic [1:0] {
        LM_8  = 2'd0,
        LM_16 = 2'd1,
        LM_32 = 2'd2,
        LM_64 = 2'd3
    } lane_mode_e;

    typedef enum logic {
        ST_EMPTY = 1'b0,
        ST_FULL  = 1'b1
    } occ_e;

    // Largest legal shift plus one for a width code: min(32, 8 << code)
    function automatic int unsigned shift_bound(input logic [1:0] code);
        int unsigned w;
        w = 32'd8 << code;
        return (w > 32) ? 32 : w;
    endfunction

endpackage

// File: rtl/bfly_lane.sv
module bfly_lane #(
    parameter int W       = 8,
    parameter int SHIFT_W = 6
) (
    input  logic [W-1:0]       t_in,
    input  logic [W-1:0]       a_in,
    input  logic [W-1:0]       b_in,
    input  logic [SHIFT_W-1:0] sh,
    output logic [W-1:0]       r_sum,
    output logic [W-1:0]       r_dif
);
    // Sum/difference need W+1 bits, product 2W+2 bits: no overflow before rounding
    localparam int EW = W + 1;
    localparam int PW = 2 * W + 2;

    logic signed [EW-1:0] s_ext, d_ext;
    logic signed [PW-1:0] s_w, d_w, b_w, p_s, p_d, half;

    always_comb begin
        s_ext = EW'($signed(t_in)) + EW'($signed(a_in));
        d_ext = EW'($signed(t_in)) - EW'($signed(a_in));
        s_w   = PW'(s_ext);
        d_w   = PW'(d_ext);
        b_w   = PW'($signed(b_in));
        p_s   = s_w * b_w;
        p_d   = d_w * b_w;
        half  = (sh == '0) ? '0 : (PW'(1) <<< (sh - SHIFT_W'(1)));
        r_sum = W'((p_s + half) >>> sh);
        r_dif = W'((p_d + half) >>> sh);
    end

endmodule

// File: rtl/bfly_array.sv
module bfly_array #(
    parameter int DATA_W  = 64,
    parameter int W       = 8,
    parameter int SHIFT_W = 6
) (
    input  logic [DATA_W-1:0]  t_word,
    input  logic [DATA_W-1:0]  a_word,
    input  logic [DATA_W-1:0]  b_word,
    input  logic [SHIFT_W-1:0] sh,
    output logic [DATA_W-1:0]  sum_word,
    output logic [DATA_W-1:0]  dif_word
);
    localparam int LANES = DATA_W / W;

    for (genvar i = 0; i < LANES; i++) begin : g_lane
        bfly_lane #(.W(W), .SHIFT_W(SHIFT_W)) u_lane (
            .t_in  (t_word[i*W +: W]),
            .a_in  (a_word[i*W +: W]),
            .b_in  (b_word[i*W +: W]),
            .sh    (sh),
            .r_sum (sum_word[i*W +: W]),
            .r_dif (dif_word[i*W +: W])
        );
    end

endmodule

// File: rtl/bfly_mac.sv
module bfly_mac
    import bfly_pkg::*;
#(
    parameter int DATA_W  = 64,
    parameter int SHIFT_W = 6
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               in_valid,
    output logic               in_ready,
    input  logic [1:0]         in_mode,
    input  logic [SHIFT_W-1:0] in_shift,
    input  logic [DATA_W-1:0]  in_t,
    input  logic [DATA_W-1:0]  in_a,
    input  logic [DATA_W-1:0]  in_b,
    output logic               out_valid,
    input  logic               out_ready,
    output logic [DATA_W-1:0]  out_sum,
    output logic [DATA_W-1:0]  out_dif
);
    localparam int NUM_MODES = 4;

    logic [DATA_W-1:0] cand_sum [NUM_MODES];
    logic [DATA_W-1:0] cand_dif [NUM_MODES];
    logic [DATA_W-1:0] pick_sum, pick_dif;

    occ_e state_q, state_d;
    logic accept;

    // One lane array per selectable width (R1)
    for (genvar k = 0; k < NUM_MODES; k++) begin : g_width
        bfly_array #(.DATA_W(DATA_W), .W(8 << k), .SHIFT_W(SHIFT_W)) u_arr (
            .t_word   (in_t),
            .a_word   (in_a),
            .b_word   (in_b),
            .sh       (in_shift),
            .sum_word (cand_sum[k]),
            .dif_word (cand_dif[k])
        );
    end

    always_comb begin
        unique case (lane_mode_e'(in_mode))
            LM_8:    begin pick_sum = cand_sum[0]; pick_dif = cand_dif[0]; end
            LM_16:   begin pick_sum = cand_sum[1]; pick_dif = cand_dif[1]; end
            LM_32:   begin pick_sum = cand_sum[2]; pick_dif = cand_dif[2]; end
            default: begin pick_sum = cand_sum[3]; pick_dif = cand_dif[3]; end
        endcase
    end

    assign accept = in_valid && in_ready;

    // Next-state and handshake outputs
    always_comb begin
        state_d   = state_q;
        in_ready  = 1'b1;
        out_valid = 1'b0;
        unique case (state_q)
            ST_EMPTY: begin
                in_ready  = 1'b1;
                out_valid = 1'b0;
                if (in_valid) state_d = ST_FULL;
            end
            ST_FULL: begin
                in_ready  = out_ready;
                out_valid = 1'b1;
                if (out_ready && !in_valid) state_d = ST_EMPTY;
            end
            default: state_d = ST_EMPTY;
        endcase
    end

    // State register
    always_ff @(posedge clk) begin
        if (!rst_n) state_q <= ST_EMPTY;
        else        state_q <= state_d;
    end

    // Result register, loaded only on accept (R10)
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            out_sum <= '0;
            out_dif <= '0;
        end else if (accept) begin
            out_sum <= pick_sum;
            out_dif <= pick_dif;
        end
    end

    AST_SHIFT_LEGAL: assert property (@(posedge clk) disable iff (!rst_n)
        accept |-> (32'(in_shift) < shift_bound(in_mode)));                    // R3
    AST_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
        accept |=> out_valid);                                                 // R8
    AST_HOLD_STALL: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid && !out_ready) |=> (out_valid && $stable(out_sum) && $stable(out_dif))); // R9
    AST_READY_WHEN_EMPTY: assert property (@(posedge clk) disable iff (!rst_n)
        !out_valid |-> in_ready);                                              // R9
    AST_DRAIN_EMPTIES: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid && out_ready && !in_valid) |=> !out_valid);                 // R9
    AST_NO_CAPTURE_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid && !accept) |=> ($stable(out_sum) && $stable(out_dif)));    // R10

endmodule

// File: tb/bfly_mac_tb.sv
module bfly_mac_tb;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        in_valid = 1'b0;
    logic        in_ready;
    logic [1:0]  in_mode = '0;
    logic [5:0]  in_shift = '0;
    logic [63:0] in_t = '0, in_a = '0, in_b = '0;
    logic        out_valid;
    logic        out_ready = 1'b1;
    logic [63:0] out_sum, out_dif;

    int n_checks = 0;
    int n_fail = 0;

    always #5 clk = ~clk;

    bfly_mac u_dut (
        .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready),
        .in_mode(in_mode), .in_shift(in_shift), .in_t(in_t), .in_a(in_a), .in_b(in_b),
        .out_valid(out_valid), .out_ready(out_ready), .out_sum(out_sum), .out_dif(out_dif)
    );

    task automatic check(input string req, input logic [63:0] got, input logic [63:0] exp);
        n_checks++;
        if (got !== exp) begin
            n_fail++;
            $display("FAIL %s: got %h expected %h", req, got, exp);
        end
    endtask

    // Reference: wide signed arithmetic per lane
    function automatic void model(input int w, input int sh, input logic [63:0] t,
                                  input logic [63:0] a, input logic [63:0] b,
                                  output logic [63:0] rs, output logic [63:0] rd);
        logic [63:0] mask;
        mask = (w == 64) ? '1 : ((64'd1 << w) - 64'd1);
        rs = '0;
        rd = '0;
        for (int i = 0; i < 64 / w; i++) begin
            logic signed [63:0]  tx, ax, bx;
            logic signed [131:0] tv, av, bv, ps, pd, h, qs, qd;
            tx = $signed((t >> (i * w)) << (64 - w)) >>> (64 - w);
            ax = $signed((a >> (i * w)) << (64 - w)) >>> (64 - w);
            bx = $signed((b >> (i * w)) << (64 - w)) >>> (64 - w);
            tv = 132'(tx); av = 132'(ax); bv = 132'(bx);
            ps = (tv + av) * bv;
            pd = (tv - av) * bv;
            h  = (sh == 0) ? 132'sd0 : (132'sd1 <<< (sh - 1));
            qs = (ps + h) >>> sh;
            qd = (pd + h) >>> sh;
            rs |= (64'(qs) & mask) << (i * w);
            rd |= (64'(qd) & mask) << (i * w);
        end
    endfunction

    task automatic run_op(input int code, input int sh, input logic [63:0] t,
                          input logic [63:0] a, input logic [63:0] b, input string tag);
        logic [63:0] es, ed;
        model(8 << code, sh, t, a, b, es, ed);
        @(negedge clk);
        in_valid = 1'b1; out_ready = 1'b1;
        in_mode = 2'(code); in_shift = 6'(sh);
        in_t = t; in_a = a; in_b = b;
        @(negedge clk);
        in_valid = 1'b0;
        check({"R8 ", tag}, 64'(out_valid), 64'd1);
        check({"R3 ", tag}, out_sum, es);
        check({"R4 ", tag}, out_dif, ed);
    endtask

    initial begin
        #2_000_000;
        n_checks++; n_fail++;
        $display("FAIL watchdog: got timeout expected completion");
        $display("  %0d/%0d checks passed", n_checks - n_fail, n_checks);
        $finish;
    end

    initial begin
        logic [63:0] es, ed;
        // R11: reset state
        repeat (3) @(negedge clk);
        check("R11 out_valid", 64'(out_valid), 64'd0);
        check("R11 in_ready", 64'(in_ready), 64'd1);
        rst_n = 1'b1;

        // R5: tie rounds up for negative product: (1+0)*(-3)=-3, shift 1 -> -1
        run_op(0, 1, 64'h01, 64'h00, 64'hFD, "R5 tie");
        check("R5 sum", out_sum, 64'h00000000000000FF);
        check("R5 dif", out_dif, 64'h00000000000000FF);

        // R2 / R7: 16-bit -1 times 2, shift 0 -> -2 in lane 0
        run_op(1, 0, 64'h000000000000FFFF, 64'h0, 64'h0000000000000002, "R2 sign");
        check("R2 sum", out_sum, 64'h000000000000FFFE);
        check("R7 dif", out_dif, 64'h000000000000FFFE);

        // R1 / R6: 8-bit lanes, (-128+1)*(-128)=16256 -> 0x80, lane 7 only
        run_op(0, 0, 64'h8000000000000000, 64'h0100000000000000, 64'h8000000000000000, "R6 wrap");
        check("R6 sum", out_sum, 64'h8000000000000000);
        check("R1 dif", out_dif, 64'h8000000000000000);

        // Sweeps over every mode and a ladder of legal shifts
        for (int code = 0; code < 4; code++) begin
            int w, lim, step;
            logic [63:0] mn, mx;
            w = 8 << code;
            lim = (w > 32) ? 32 : w;
            step = lim / 8;
            mn = '0;
            for (int i = 0; i < 64 / w; i++) mn[i*w + w - 1] = 1'b1;
            mx = ~mn;
            for (int sh = 0; sh <= lim; sh += step) begin
                int s;
                s = (sh >= lim) ? lim - 1 : sh;
                run_op(code, s, mn, mn, mn, "R6 minmin");
                run_op(code, s, mn, mx, mn, "R6 minmax");
                run_op(code, s, mx, mx, mx, "R6 maxmax");
                run_op(code, s, mx, mn, mn, "R6 maxmin");
                for (int r = 0; r < 6; r++)
                    run_op(code, s, {$urandom, $urandom}, {$urandom, $urandom},
                           {$urandom, $urandom}, "R1 random");
            end
        end

        // R8: back-to-back accepts, one per cycle
        @(negedge clk);
        in_valid = 1'b1; out_ready = 1'b1; in_mode = 2'd2; in_shift = 6'd3;
        in_t = 64'h1234567887654321; in_a = 64'h0F0F0F0FF0F0F0F0; in_b = 64'h7FFFFFFF80000001;
        @(negedge clk);
        model(32, 3, 64'h1234567887654321, 64'h0F0F0F0FF0F0F0F0, 64'h7FFFFFFF80000001, es, ed);
        check("R8 b2b ready", 64'(in_ready), 64'd1);
        check("R8 b2b first", out_sum, es);
        in_mode = 2'd3; in_shift = 6'd31;
        in_t = 64'h8000000000000000; in_a = 64'h8000000000000000; in_b = 64'h8000000000000000;
        @(negedge clk);
        in_valid = 1'b0;
        model(64, 31, 64'h8000000000000000, 64'h8000000000000000, 64'h8000000000000000, es, ed);
        check("R8 b2b second sum", out_sum, es);
        check("R8 b2b second dif", out_dif, ed);

        // R9 / R10: stall holds result; later input changes ignored
        @(negedge clk);
        in_valid = 1'b1; in_mode = 2'd0; in_shift = 6'd2;
        in_t = 64'h7F80017F80017F80; in_a = 64'h0102030405060708; in_b = 64'hF0E0D0C0B0A09080;
        @(negedge clk);
        model(8, 2, 64'h7F80017F80017F80, 64'h0102030405060708, 64'hF0E0D0C0B0A09080, es, ed);
        in_valid = 1'b0; out_ready = 1'b0;
        in_mode = 2'd3; in_shift = 6'd0; in_t = '1; in_a = '0; in_b = '1;
        @(negedge clk);
        check("R9 stall valid", 64'(out_valid), 64'd1);
        check("R9 stall ready", 64'(in_ready), 64'd0);
        check("R10 held sum", out_sum, es);
        check("R10 held dif", out_dif, ed);
        out_ready = 1'b1;
        @(negedge clk);
        check("R9 drained", 64'(out_valid), 64'd0);
        check("R9 ready empty", 64'(in_ready), 64'd1);

        $display("  %0d/%0d checks passed", n_checks - n_fail, n_checks);
        $finish;
    end

endmodule